// File: doc/BRIEF.md
# Multiplexed NAND Command Responder

This block is a synthesizable stand-in for the control logic of a small multiplexed NAND flash part, used as the self-checking partner of a host flash controller. The host drives chip enable, command latch, address latch, write strobe, read strobe, write protect and an 8-bit input bus. All of these are sampled on the system clock, and the rising edges of the two strobes mark bus cycles. The block answers on an 8-bit output bus with an output enable and on a ready/busy line.

Commands, address bytes and data bytes are decoded into page read, cache read, page program with column jumps, block erase, identification, status and reset. The storage array is held internally with parameterised dimensions (default 4 blocks of 4 pages of 64 bytes). Array transfers run one byte per clock inside a busy window whose length in cycles is a parameter, one per operation. Each block records the next page it is willing to program, and a program aimed at any other page fails.

Addressing: the first address byte carries the column. The third address byte carries the row, with the page in its low log2(PAGES) bits and the block above them. The second, fourth and fifth address bytes are accepted and ignored.

Top module: `nandm_top`

## Requirements
- R1: Command 00h, five address bytes and then 30h drive rb_n low for T_READ cycles while the addressed page is fetched. Afterwards, each read strobe pulse returns the next byte, starting at the given column.
- R2: After a page read, 31h moves the fetched page to the output and fetches the following row while busy. 3Fh moves the fetched page to the output without a new fetch and leaves rb_n high. Output restarts at column 0 in both cases.
- R3: Command 80h, five address bytes, data bytes and then 10h write the page and hold rb_n low for T_PROG cycles. Columns that receive no data read back as FFh.
- R4: Within a program, 85h followed by two address bytes moves the data column inside the same page, and the row is kept.
- R5: Each block accepts programs only at its next page in ascending order from page 0. Any other page leaves the array unchanged and sets status bit 0. A successful program clears that bit.
- R6: With wp_n low, 10h and D0h start nothing: rb_n stays high and the array is unchanged. Status bit 7 reads 0.
- R7: After 70h, the status byte is driven whenever ce_n and re_n are low, and it follows changes without a strobe toggle. Bit 7 is wp_n, bits 6 and 5 are ready (equal to rb_n), bits 4..1 are 0, and bit 0 is the program fail flag.
- R8: Command 60h, three row address bytes and then D0h set every byte of the block to FFh over T_ERASE cycles, and let the block be programmed again from page 0.
- R9: FFh, accepted even while busy, aborts any operation, is busy for T_RESET cycles and clears the fail flag. Status then reads E0h, or 60h with wp_n low. This is also the state after rst_n.
- R10: 90h followed by one address byte returns ID_MAKER and then ID_DEVICE on successive read strobe pulses.
- R11: An unknown command byte is ignored and returns the interpreter to idle: any pending setup is dropped and no output is driven.
- R12: io_oe is high only while ce_n and re_n are both low and an output mode (data, status or ID) is selected.
- R13: Write strobe edges while ce_n is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a write cycle as a command |
| ale | input | 1 | Marks a write cycle as an address byte |
| we_n | input | 1 | Write strobe, cycle taken on its rising edge |
| re_n | input | 1 | Read strobe, output while low, advances on rising edge |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte driven by the host |
| io_out | output | 8 | Byte driven to the host |
| io_oe | output | 1 | High while io_out is valid |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
A wrong column or row pointer shows up in the first byte read back after the next page read. A lost page-order entry shows up in the status fail bit one program later. A stuck operation engine holds rb_n low past its window, and status bit 6 disagrees with rb_n within the same cycle. The bench programs and reads every page of the small array against an arithmetic byte pattern, so a corrupted transfer appears as a data mismatch on the first affected byte.

// File: rtl/nandm_pkg.sv
package nandm_pkg;
   typedef enum logic [1:0] {OM_NONE, OM_DATA, OM_STAT, OM_ID} omode_t;
   typedef enum logic [2:0] {OP_IDLE, OP_LOAD, OP_PROG, OP_ERASE, OP_WAIT} op_t;
   typedef enum logic [1:0] {SU_NONE, SU_READ, SU_ERASE} setup_t;

   localparam logic [7:0] C_READ      = 8'h00;
   localparam logic [7:0] C_READ_GO   = 8'h30;
   localparam logic [7:0] C_CACHE     = 8'h31;
   localparam logic [7:0] C_CACHE_END = 8'h3F;
   localparam logic [7:0] C_PROG      = 8'h80;
   localparam logic [7:0] C_COLJMP    = 8'h85;
   localparam logic [7:0] C_PROG_GO   = 8'h10;
   localparam logic [7:0] C_ERASE     = 8'h60;
   localparam logic [7:0] C_ERASE_GO  = 8'hD0;
   localparam logic [7:0] C_IDENT     = 8'h90;
   localparam logic [7:0] C_STAT      = 8'h70;
   localparam logic [7:0] C_RESET     = 8'hFF;
endpackage

// File: rtl/nandm_strobe.sv
module nandm_strobe #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   for (genvar i = 0; i < N; i++) begin : g_line
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev <= 1'b1;
         else        prev <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev;
   end
endmodule

// File: rtl/nandm_store.sv
module nandm_store #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          wr,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];
   always_ff @(posedge clk) begin
      if (wr) mem[waddr] <= wdata;
   end
   assign rdata = mem[raddr];
endmodule

// File: rtl/nandm_top.sv
module nandm_top
   import nandm_pkg::*;
#(
   parameter int BLOCKS  = 4,
   parameter int PAGES   = 4,
   parameter int BYTES   = 64,
   parameter int T_READ  = 80,
   parameter int T_PROG  = 100,
   parameter int T_ERASE = 300,
   parameter int T_RESET = 10,
   parameter logic [7:0] ID_MAKER  = 8'hA5,
   parameter logic [7:0] ID_DEVICE = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce_n,
   input  logic       cle,
   input  logic       ale,
   input  logic       we_n,
   input  logic       re_n,
   input  logic       wp_n,
   input  logic [7:0] io_in,
   output logic [7:0] io_out,
   output logic       io_oe,
   output logic       rb_n
);
   localparam int COL_W = $clog2(BYTES);
   localparam int PG_W  = $clog2(PAGES);
   localparam int BLK_W = $clog2(BLOCKS);
   localparam int ROW_W = PG_W + BLK_W;
   localparam int AW    = ROW_W + COL_W;
   localparam int DEPTH = BLOCKS * PAGES * BYTES;
   localparam int IDX_W = PG_W + COL_W + 1;
   localparam int CNT_W = $clog2(T_READ + T_PROG + T_ERASE + T_RESET + 1);
   localparam logic [IDX_W-1:0] BYTES_I = IDX_W'(BYTES);
   localparam logic [IDX_W-1:0] BLOCK_I = IDX_W'(PAGES * BYTES);

   if (BYTES < 2 || (1 << COL_W) != BYTES || COL_W > 8) begin : g_bad_bytes
      $error("BYTES must be a power of two from 2 to 256");
   end
   if (PAGES < 2 || BLOCKS < 2 || (1 << PG_W) != PAGES || (1 << BLK_W) != BLOCKS || ROW_W > 8) begin : g_bad_rows
      $error("PAGES and BLOCKS must be powers of two with at most 8 row bits");
   end
   if (T_READ < BYTES || T_PROG < BYTES || T_ERASE < PAGES * BYTES || T_RESET < 1) begin : g_bad_times
      $error("busy windows too short for byte-serial transfer");
   end

   logic [1:0] rise;
   nandm_strobe #(.N(2)) u_strobe (.clk(clk), .rst_n(rst_n), .lvl({re_n, we_n}), .rise(rise));

   op_t               op;
   omode_t            mode;
   setup_t            su;
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [COL_W-1:0]  col;
   logic [ROW_W-1:0]  row;
   logic [2:0]        acnt, aend;
   logic              prog_open, rd_valid, fail, prog_ok, load_show;
   logic [1:0]        id_idx;
   logic [PG_W:0]     nextpg [BLOCKS];
   logic [7:0]        dreg [BYTES];
   logic [7:0]        obuf [BYTES];
   logic              mwr;
   logic [AW-1:0]     mwaddr;
   logic [7:0]        mwdata, mrdata;
   logic              stat_view;

   wire busy    = (op != OP_IDLE);
   wire we_up   = rise[0] & ~ce_n;
   wire re_up   = rise[1] & ~ce_n;
   wire cmd_cyc = we_up & cle & ~ale;
   wire adr_cyc = we_up & ale & ~cle;
   wire dat_wr  = we_up & ~cle & ~ale & ~busy & prog_open & (acnt == aend);
   wire [BLK_W-1:0] blk = row[ROW_W-1:PG_W];
   wire [PG_W-1:0]  pg  = row[PG_W-1:0];
   wire fill    = cmd_cyc & ~busy & (io_in == C_PROG);
   wire to_out  = cmd_cyc & ~busy & rd_valid & ((io_in == C_CACHE) | (io_in == C_CACHE_END));
   wire load_wr = (op == OP_LOAD) & (idx < BYTES_I);

   nandm_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk), .wr(mwr), .waddr(mwaddr), .wdata(mwdata),
      .raddr({row, idx[COL_W-1:0]}), .rdata(mrdata));

   always_comb begin
      mwr    = 1'b0;
      mwaddr = {row, idx[COL_W-1:0]};
      mwdata = dreg[idx[COL_W-1:0]];
      if (op == OP_PROG) begin
         mwr = prog_ok & (idx < BYTES_I);
      end else if (op == OP_ERASE) begin
         mwr    = idx < BLOCK_I;
         mwaddr = {blk, idx[PG_W+COL_W-1:0]};
         mwdata = 8'hFF;
      end
   end

   // Page and output registers: byte-serial fill from the array (R1, R2, R3)
   always_ff @(posedge clk) begin
      if (fill) begin
         for (int i = 0; i < BYTES; i++) dreg[i] <= 8'hFF;
      end else if (dat_wr) begin
         dreg[col] <= io_in;
      end
      if (to_out) obuf <= dreg;
      if (load_wr) begin
         dreg[idx[COL_W-1:0]] <= mrdata;
         if (load_show) obuf[idx[COL_W-1:0]] <= mrdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op <= OP_IDLE;  mode <= OM_NONE;  su <= SU_NONE;
         cnt <= '0;  idx <= '0;  col <= '0;  row <= '0;
         acnt <= 3'd5;  aend <= 3'd5;  id_idx <= '0;
         prog_open <= 1'b0;  rd_valid <= 1'b0;  fail <= 1'b0;
         prog_ok <= 1'b0;  load_show <= 1'b0;
         for (int b = 0; b < BLOCKS; b++) nextpg[b] <= '0;
      end else begin
         if (busy) begin
            if (idx != '1) idx <= idx + 1'b1;
            cnt <= cnt - 1'b1;
            if (cnt == '0) op <= OP_IDLE;
         end
         if (re_up && mode == OM_DATA) col <= col + 1'b1;
         if (re_up && mode == OM_ID && id_idx != 2'd3) id_idx <= id_idx + 1'b1;
         if (dat_wr) col <= col + 1'b1;
         if (adr_cyc && !busy && acnt != aend) begin
            if (acnt == 3'd0) col <= io_in[COL_W-1:0];
            if (acnt == 3'd2) row <= io_in[ROW_W-1:0];
            acnt <= acnt + 1'b1;
         end
         if (cmd_cyc) begin
            if (io_in == C_RESET) begin
               op <= OP_WAIT;  cnt <= CNT_W'(T_RESET - 1);  fail <= 1'b0;
               su <= SU_NONE;  mode <= OM_NONE;  prog_open <= 1'b0;
               acnt <= 3'd5;  aend <= 3'd5;
            end else if (io_in == C_STAT) begin
               mode <= OM_STAT;
            end else if (!busy) begin
               case (io_in)
                  C_READ: begin
                     su <= SU_READ;  acnt <= 3'd0;  aend <= 3'd5;
                     mode <= OM_NONE;  prog_open <= 1'b0;
                  end
                  C_READ_GO: begin
                     if (su == SU_READ && acnt == aend) begin
                        op <= OP_LOAD;  cnt <= CNT_W'(T_READ - 1);  idx <= '0;
                        load_show <= 1'b1;  rd_valid <= 1'b1;  mode <= OM_DATA;
                     end else mode <= OM_NONE;
                     su <= SU_NONE;
                  end
                  C_CACHE: begin
                     if (rd_valid) begin
                        op <= OP_LOAD;  cnt <= CNT_W'(T_READ - 1);  idx <= '0;
                        load_show <= 1'b0;  row <= row + 1'b1;  col <= '0;
                        mode <= OM_DATA;
                     end
                     su <= SU_NONE;
                  end
                  C_CACHE_END: begin
                     if (rd_valid) begin
                        col <= '0;  mode <= OM_DATA;  rd_valid <= 1'b0;
                     end
                     su <= SU_NONE;
                  end
                  C_PROG: begin
                     su <= SU_NONE;  acnt <= 3'd0;  aend <= 3'd5;
                     prog_open <= 1'b1;  rd_valid <= 1'b0;  mode <= OM_NONE;
                  end
                  C_COLJMP: begin
                     if (prog_open) begin
                        acnt <= 3'd0;  aend <= 3'd2;
                     end
                  end
                  C_PROG_GO: begin
                     if (prog_open && acnt == aend && wp_n) begin
                        op <= OP_PROG;  cnt <= CNT_W'(T_PROG - 1);  idx <= '0;
                        if ({1'b0, pg} == nextpg[blk]) begin
                           prog_ok <= 1'b1;  fail <= 1'b0;
                           nextpg[blk] <= nextpg[blk] + 1'b1;
                        end else begin
                           prog_ok <= 1'b0;  fail <= 1'b1;
                        end
                     end
                     prog_open <= 1'b0;  su <= SU_NONE;
                  end
                  C_ERASE: begin
                     su <= SU_ERASE;  acnt <= 3'd2;  aend <= 3'd5;
                     mode <= OM_NONE;  prog_open <= 1'b0;
                  end
                  C_ERASE_GO: begin
                     if (su == SU_ERASE && acnt == aend && wp_n) begin
                        op <= OP_ERASE;  cnt <= CNT_W'(T_ERASE - 1);  idx <= '0;
                        nextpg[blk] <= '0;
                     end
                     su <= SU_NONE;
                  end
                  C_IDENT: begin
                     mode <= OM_ID;  id_idx <= '0;  su <= SU_NONE;
                     acnt <= 3'd5;  aend <= 3'd5;  prog_open <= 1'b0;
                  end
                  default: begin
                     su <= SU_NONE;  mode <= OM_NONE;  prog_open <= 1'b0;
                  end
               endcase
            end
         end
      end
   end

   always_comb begin
      case (mode)
         OM_DATA: io_out = obuf[col];
         OM_STAT: io_out = {wp_n, ~busy, ~busy, 4'b0000, fail};
         OM_ID:   io_out = (id_idx == 2'd0) ? ID_MAKER : (id_idx == 2'd1) ? ID_DEVICE : 8'h00;
         default: io_out = 8'h00;
      endcase
   end

   assign io_oe     = (mode != OM_NONE) & ~ce_n & ~re_n;
   assign rb_n      = ~busy;
   assign stat_view = (mode == OM_STAT);
endmodule

// File: rtl/nandm_chk.sv
module nandm_chk #(
   parameter int BUSY_MAX = 1024
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_n,
   input logic       cle,
   input logic       ale,
   input logic       we_n,
   input logic       re_n,
   input logic       wp_n,
   input logic [7:0] io_in,
   input logic [7:0] io_out,
   input logic       io_oe,
   input logic       rb_n,
   input logic       stat_view
);
   logic        we_prev;
   logic [15:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_prev  <= 1'b1;
         busy_run <= '0;
      end else begin
         we_prev  <= we_n;
         busy_run <= rb_n ? 16'd0 : busy_run + 16'd1;
      end
   end

   wire commit_try = we_n & ~we_prev & ~ce_n & cle & ~ale &
                     ((io_in == 8'h10) | (io_in == 8'hD0));

   AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe |-> (!ce_n && !re_n)); // R12
   AST_STATUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe && stat_view) |-> (io_out[6] == rb_n && io_out[5] == rb_n)); // R7
   AST_STATUS_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      (io_oe && stat_view) |-> (io_out[7] == wp_n)); // R6
   AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_try && !wp_n && rb_n) |=> rb_n); // R6
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 16'(BUSY_MAX)); // R9
endmodule

bind nandm_top nandm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
   .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
   .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n), .stat_view(stat_view));

// File: tb/nandm_top_test.sv
module nandm_top_test;
   localparam int BLOCKS = 4;
   localparam int PAGES  = 4;
   localparam int BYTES  = 64;
   localparam int DEPTH  = BLOCKS * PAGES * BYTES;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
   logic [7:0] io_in = 8'h00;
   logic [7:0] io_out;
   logic io_oe, rb_n;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [DEPTH];

   always #2 clk = ~clk;

   nandm_top uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
      .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n));

   function automatic logic [7:0] pat(int b, int p, int c, int off);
      return 8'((b * 37 + p * 11 + c * 3 + 5 + off) & 255);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic c, logic a, logic [7:0] v);
      cle = c; ale = a; io_in = v; tick(1);
      we_n = 1'b0; tick(2);
      we_n = 1'b1; tick(2);
      cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(logic [7:0] v);  bus_wr(1'b1, 1'b0, v); endtask
   task automatic adr(logic [7:0] v);  bus_wr(1'b0, 1'b1, v); endtask
   task automatic din(logic [7:0] v);  bus_wr(1'b0, 1'b0, v); endtask

   task automatic rd(output logic [7:0] v, output logic oe);
      re_n = 1'b0; tick(1);
      v = io_out; oe = io_oe;
      re_n = 1'b1; tick(2);
   endtask

   task automatic addr5(int c, int r);
      adr(8'(c)); adr(8'h00); adr(8'(r)); adr(8'h00); adr(8'h00);
   endtask

   task automatic wait_rdy(string req);
      int n = 0;
      while (!rb_n && n < 4000) begin tick(1); n++; end
      if (!rb_n) check(req, 16'h0, 16'h1);
   endtask

   task automatic status_is(string req, logic [7:0] exp);
      logic [7:0] v; logic oe;
      cmd(8'h70); rd(v, oe);
      check(req, {7'b0, oe, v}, {7'b0, 1'b1, exp});
   endtask

   task automatic erase_blk(int b, string req);
      cmd(8'h60); adr(8'(b * PAGES)); adr(8'h00); adr(8'h00); cmd(8'hD0);
      check(req, 16'(rb_n), 16'h0);
      wait_rdy(req);
   endtask

   task automatic prog_page(int b, int p, int off, string req);
      cmd(8'h80); addr5(0, b * PAGES + p);
      for (int c = 0; c < BYTES; c++) din(pat(b, p, c, off));
      cmd(8'h10);
      check(req, 16'(rb_n), 16'h0);
      wait_rdy(req);
   endtask

   task automatic read_page(int b, int p, int start, string req);
      logic [7:0] v; logic oe;
      cmd(8'h00); addr5(start, b * PAGES + p); cmd(8'h30);
      check(req, 16'(rb_n), 16'h0);
      wait_rdy(req);
      for (int c = start; c < BYTES; c++) begin
         rd(v, oe);
         check(req, {7'b0, oe, v}, {7'b0, 1'b1, model[(b * PAGES + p) * BYTES + c]});
      end
   endtask

   task automatic stream_page(int b, int p, string req);
      logic [7:0] v; logic oe;
      for (int c = 0; c < BYTES; c++) begin
         rd(v, oe);
         check(req, {7'b0, oe, v}, {7'b0, 1'b1, model[(b * PAGES + p) * BYTES + c]});
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [7:0] v; logic oe;
      tick(3); rst_n = 1'b1; tick(2);

      // R9 / R12: reset state
      check("R9 rb_n after reset", 16'(rb_n), 16'h1);
      check("R12 oe idle", 16'(io_oe), 16'h0);
      status_is("R9 status after reset", 8'hE0);

      // R8: erase whole array
      for (int b = 0; b < BLOCKS; b++) begin
         erase_blk(b, "R8 erase");
         for (int i = 0; i < PAGES * BYTES; i++) model[b * PAGES * BYTES + i] = 8'hFF;
      end
      read_page(1, 2, 0, "R8 erased page");

      // R3 / R5: in-order programming of every page
      for (int b = 0; b < BLOCKS; b++)
         for (int p = 0; p < PAGES; p++) begin
            prog_page(b, p, 0, "R3 program");
            for (int c = 0; c < BYTES; c++) model[(b * PAGES + p) * BYTES + c] = pat(b, p, c, 0);
            status_is("R5 in-order pass", 8'hE0);
         end

      // R1: read every page, and from a middle column
      for (int b = 0; b < BLOCKS; b++)
         for (int p = 0; p < PAGES; p++) read_page(b, p, 0, "R1 page read");
      read_page(0, 3, 40, "R1 start column");

      // R2: cache read sequence on block 2
      read_page(2, 0, 0, "R2 first fetch");
      cmd(8'h31); wait_rdy("R2 cache");
      stream_page(2, 0, "R2 cache first");
      cmd(8'h31); wait_rdy("R2 cache");
      stream_page(2, 1, "R2 cache second");
      cmd(8'h3F);
      check("R2 last no busy", 16'(rb_n), 16'h1);
      stream_page(2, 2, "R2 cache last");

      // R7 / R8: live status during erase
      cmd(8'h60); adr(8'(2 * PAGES)); adr(8'h00); adr(8'h00); cmd(8'hD0);
      cmd(8'h70);
      re_n = 1'b0; tick(1);
      check("R7 live busy status", {7'b0, io_oe, io_out}, 16'h180);
      while (!rb_n) tick(1);
      tick(1);
      check("R7 live ready status", {7'b0, io_oe, io_out}, 16'h1E0);
      re_n = 1'b1; tick(2);
      for (int i = 0; i < PAGES * BYTES; i++) model[2 * PAGES * BYTES + i] = 8'hFF;
      read_page(2, 1, 0, "R8 block cleared");

      // R5: page order enforcement
      prog_page(2, 2, 0, "R5 out of order");
      status_is("R5 fail bit", 8'hE1);
      read_page(2, 2, 0, "R5 untouched page");
      prog_page(2, 0, 0, "R5 first page");
      for (int c = 0; c < BYTES; c++) model[(2 * PAGES) * BYTES + c] = pat(2, 0, c, 0);
      status_is("R5 pass clears fail", 8'hE0);
      prog_page(2, 0, 99, "R5 repeat page");
      status_is("R5 repeat fails", 8'hE1);
      read_page(2, 0, 0, "R5 repeat keeps data");

      // R9: reset clears fail
      cmd(8'hFF);
      check("R9 reset busy", 16'(rb_n), 16'h0);
      wait_rdy("R9 reset");
      status_is("R9 fail cleared", 8'hE0);

      // R4: column jump inside a program
      erase_blk(1, "R8 erase block1");
      for (int i = 0; i < PAGES * BYTES; i++) model[PAGES * BYTES + i] = 8'hFF;
      cmd(8'h80); addr5(0, PAGES);
      din(8'h11); din(8'h22); din(8'h33); din(8'h44);
      cmd(8'h85); adr(8'd20); adr(8'h00);
      din(8'h55); din(8'h66);
      cmd(8'h10); wait_rdy("R4 program");
      model[PAGES * BYTES + 0]  = 8'h11; model[PAGES * BYTES + 1]  = 8'h22;
      model[PAGES * BYTES + 2]  = 8'h33; model[PAGES * BYTES + 3]  = 8'h44;
      model[PAGES * BYTES + 20] = 8'h55; model[PAGES * BYTES + 21] = 8'h66;
      status_is("R4 same page accepted", 8'hE0);
      read_page(1, 0, 0, "R4 jumped data");

      // R6: write protect
      wp_n = 1'b0; tick(1);
      status_is("R6 protect status", 8'h60);
      cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
      check("R6 erase blocked", 16'(rb_n), 16'h1);
      cmd(8'h80); addr5(0, 2 * PAGES + 1);
      for (int c = 0; c < BYTES; c++) din(pat(2, 1, c, 0));
      cmd(8'h10);
      check("R6 program blocked", 16'(rb_n), 16'h1);
      read_page(0, 0, 0, "R6 block0 intact");
      read_page(2, 1, 0, "R6 page not written");
      cmd(8'hFF); wait_rdy("R9 reset protected");
      status_is("R9 reset with protect", 8'h60);
      wp_n = 1'b1; tick(1);

      // R10: identification
      cmd(8'h90); adr(8'h00);
      rd(v, oe); check("R10 maker", {7'b0, oe, v}, 16'h1A5);
      rd(v, oe); check("R10 device", {7'b0, oe, v}, 16'h15A);

      // R11: unknown command
      cmd(8'h70); cmd(8'hC3);
      re_n = 1'b0; tick(1);
      check("R11 no output", 16'(io_oe), 16'h0);
      re_n = 1'b1; tick(2);
      cmd(8'h00); addr5(0, 0); cmd(8'hC3); cmd(8'h30);
      check("R11 setup dropped", 16'(rb_n), 16'h1);

      // R13 / R12: chip enable high
      ce_n = 1'b1;
      cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0);
      check("R13 erase ignored", 16'(rb_n), 16'h1);
      cmd(8'h70);
      re_n = 1'b0; tick(1);
      check("R12 oe with ce high", 16'(io_oe), 16'h0);
      re_n = 1'b1; tick(2);
      ce_n = 1'b0; tick(1);
      read_page(0, 0, 0, "R13 block0 intact");

      finish_run();
   end
endmodule